// File: doc/BRIEF.md
# Fractional Serial Reference Clock Enable Generator

This block turns one fast master clock into two slower timing strobes without a second clock domain. The first strobe paces a serial controller whose reference must run at the master rate divided by 4.25. That ratio is not an integer, so the block varies the length of its output periods. Three periods of four master cycles are followed by one period of five, which gives exactly four output periods in every seventeen master cycles. With a master clock near 15.667 MHz the average output lands near 3.686 MHz, which suits a 230.4 kbaud link. A two-bit phase counter picks the length of each period, and a small cycle counter runs through that period.

For each period the block gives a level output and a one-cycle strobe. The level output is high for the first two master cycles of the period. The strobe marks the first cycle of the period. A second strobe, asserted on every other master cycle, serves as a divide-by-two processor clock enable. A synchronous reset holds every output low. After reset the sequence always starts from the first short period.

Top module: `frac_clk_div`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, all three outputs are low after that edge.
- R2: After `rst` falls, the first rising edge with `rst` low starts the sequence, so `ser_en`, `ser_clk` and `cpu_en` are all high in the cycle that follows that edge.
- R3: The distance between consecutive `ser_en` pulses follows the repeating order 4, 4, 4, 5 master cycles, and the first distance after reset is 4.
- R4: Any window of 17 consecutive master cycles aligned to the post-reset start holds exactly 4 `ser_en` pulses.
- R5: `ser_en` is high for exactly one master cycle, and only in the first cycle of each output period.
- R6: `ser_clk` is high in the first 2 master cycles of every output period and low in the remaining 2 or 3 cycles.
- R7: Once running, `cpu_en` alternates every master cycle. It is high in the first running cycle, so it is high on even cycle counts since the start.
- R8: A reset applied at any point of the 17-cycle pattern restarts the sequence from its first short period, with the same timing as after the first reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk | output | 1 | Serial reference level, high for the first two cycles of each period |
| ser_en | output | 1 | One-cycle strobe at the start of each serial period |
| cpu_en | output | 1 | Divide-by-two processor clock enable |

## Verification
The main pattern is a long free run of eight full 17-cycle frames. In this run every output is compared, cycle by cycle, against an arithmetic model of the position within the frame. That run separates a wrong long-period slot or a wrong long-period length, which shifts every later strobe, from a wrong duty width, which changes only `ser_clk`. The second pattern applies reset at each of the 17 frame positions and then checks 40 cycles afterwards. A phase counter or a toggle that reset leaves alone would show up as a shifted pattern at one or more of those positions. Per-frame pulse counts and the gap order, 4 4 4 5, separate a wrong average ratio from a rotated order that keeps the same average.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
   // Terminal count of a period of the given length (counter runs 0..len-1).
   function automatic int unsigned fdiv_term(input int unsigned len);
      return len - 1;
   endfunction

   // Counter width able to hold the terminal count of the longest period.
   function automatic int unsigned fdiv_cnt_w(input int unsigned len);
      return (len > 2) ? $clog2(len) : 1;
   endfunction
endpackage

// File: rtl/fdiv_phase_seq.sv
module fdiv_phase_seq #(
   parameter int unsigned N_PHASE    = 4,
   parameter int unsigned LONG_PHASE = 3,
   localparam int unsigned PH_W      = (N_PHASE > 2) ? $clog2(N_PHASE) : 1,
   localparam int unsigned LAST_PH   = N_PHASE - 1
) (
   input  logic clk,
   input  logic rst,
   input  logic adv,
   output logic long_sel
);
   logic [PH_W-1:0] ph_q;

   initial begin : prm_chk
      assert (N_PHASE >= 1) else $error("fdiv_phase_seq: N_PHASE must be at least 1");
      assert (LONG_PHASE < N_PHASE) else $error("fdiv_phase_seq: LONG_PHASE out of range");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ph_q <= '0;
      end else if (adv) begin
         if (ph_q == PH_W'(LAST_PH)) ph_q <= '0;
         else                        ph_q <= ph_q + 1'b1;
      end
   end

   assign long_sel = (ph_q == PH_W'(LONG_PHASE));

   // R3
   phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !adv |=> $stable(ph_q));

   // R3
   phase_range_chk: assert property (@(posedge clk) disable iff (rst)
      ph_q <= PH_W'(LAST_PH));
endmodule

// File: rtl/fdiv_period_cnt.sv
module fdiv_period_cnt
   import fdiv_pkg::*;
#(
   parameter int unsigned SHORT_LEN = 4,
   parameter int unsigned LONG_LEN  = 5,
   parameter int unsigned HIGH_CYC  = 2,
   localparam int unsigned CNT_W      = fdiv_cnt_w(LONG_LEN),
   localparam int unsigned SHORT_TERM = fdiv_term(SHORT_LEN),
   localparam int unsigned LONG_TERM  = fdiv_term(LONG_LEN)
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   input  logic long_sel,
   output logic start,
   output logic high,
   output logic wrap
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] term;

   initial begin : prm_chk
      assert (SHORT_LEN >= 2) else $error("fdiv_period_cnt: SHORT_LEN below 2");
      assert (LONG_LEN >= SHORT_LEN) else $error("fdiv_period_cnt: LONG_LEN below SHORT_LEN");
      assert (HIGH_CYC >= 1 && HIGH_CYC < SHORT_LEN) else $error("fdiv_period_cnt: HIGH_CYC out of range");
   end

   assign term = long_sel ? CNT_W'(LONG_TERM) : CNT_W'(SHORT_TERM);
   assign wrap = run && (cnt_q == term);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (run) begin
         if (wrap) cnt_q <= '0;
         else      cnt_q <= cnt_q + 1'b1;
      end
   end

   assign start = run && (cnt_q == '0);
   assign high  = run && (cnt_q < CNT_W'(HIGH_CYC));

   // R3
   cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= CNT_W'(LONG_TERM));

   // R3
   short_bound_chk: assert property (@(posedge clk) disable iff (rst)
      !long_sel |-> cnt_q <= CNT_W'(SHORT_TERM));
endmodule

// File: rtl/fdiv_cpu_en.sv
module fdiv_cpu_en #(
   parameter int unsigned CPU_DIV = 2,
   localparam int unsigned DV_W   = (CPU_DIV > 2) ? $clog2(CPU_DIV) : 1
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   output logic en
);
   initial begin : prm_chk
      assert (CPU_DIV >= 1) else $error("fdiv_cpu_en: CPU_DIV must be at least 1");
   end

   generate
      if (CPU_DIV == 1) begin : g_pass
         assign en = run;
      end else begin : g_div
         logic [DV_W-1:0] dv_q;
         always_ff @(posedge clk) begin
            if (rst || !run)                     dv_q <= '0;
            else if (dv_q == DV_W'(CPU_DIV - 1)) dv_q <= '0;
            else                                 dv_q <= dv_q + 1'b1;
         end
         assign en = run && (dv_q == '0);

         // R7
         cpu_gap_chk: assert property (@(posedge clk) disable iff (rst)
            en |=> !en);
      end
   endgenerate
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div #(
   parameter int unsigned SHORT_LEN  = 4,
   parameter int unsigned LONG_LEN   = 5,
   parameter int unsigned N_PHASE    = 4,
   parameter int unsigned LONG_PHASE = 3,
   parameter int unsigned HIGH_CYC   = 2,
   parameter int unsigned CPU_DIV    = 2
) (
   input  logic clk,
   input  logic rst,
   output logic ser_clk,
   output logic ser_en,
   output logic cpu_en
);
   logic run_q;
   logic long_sel;
   logic wrap;
   logic start;
   logic high;

   always_ff @(posedge clk) begin
      if (rst) run_q <= 1'b0;
      else     run_q <= 1'b1;
   end

   fdiv_phase_seq #(
      .N_PHASE    (N_PHASE),
      .LONG_PHASE (LONG_PHASE)
   ) u_phase (
      .clk      (clk),
      .rst      (rst),
      .adv      (wrap),
      .long_sel (long_sel)
   );

   fdiv_period_cnt #(
      .SHORT_LEN (SHORT_LEN),
      .LONG_LEN  (LONG_LEN),
      .HIGH_CYC  (HIGH_CYC)
   ) u_period (
      .clk      (clk),
      .rst      (rst),
      .run      (run_q),
      .long_sel (long_sel),
      .start    (start),
      .high     (high),
      .wrap     (wrap)
   );

   fdiv_cpu_en #(
      .CPU_DIV (CPU_DIV)
   ) u_cpu (
      .clk (clk),
      .rst (rst),
      .run (run_q),
      .en  (cpu_en)
   );

   assign ser_en  = start;
   assign ser_clk = high;

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      rst |=> (!ser_en && !ser_clk && !cpu_en));

   // R5
   en_single_chk: assert property (@(posedge clk) disable iff (rst)
      ser_en |=> !ser_en);

   // R6
   en_in_high_chk: assert property (@(posedge clk) disable iff (rst)
      ser_en |-> ser_clk);

   // R2
   start_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(run_q) |-> (ser_en && cpu_en));
endmodule

// File: tb/frac_clk_div_bench.sv
module frac_clk_div_bench;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ser_clk, ser_en, cpu_en;
   int   total = 0;
   int   bad   = 0;
   bit   done  = 1'b0;

   always #2.5 clk = ~clk;

   frac_clk_div u_frac_clk_div (
      .clk     (clk),
      .rst     (rst),
      .ser_clk (ser_clk),
      .ser_en  (ser_en),
      .cpu_en  (cpu_en)
   );

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // Runs n cycles from the post-reset start, comparing against the frame model.
   task automatic run_seq(input int n, output int pulses);
      int last = -1;
      int seen = 0;
      for (int k = 0; k < n; k++) begin
         int pos = k % 17;
         int off = (pos < 12) ? (pos % 4) : (pos - 12);
         check("R5", int'(ser_en),  (off == 0) ? 1 : 0);
         check("R6", int'(ser_clk), (off < 2)  ? 1 : 0);
         check("R7", int'(cpu_en),  (k % 2 == 0) ? 1 : 0);
         if (ser_en) begin
            if (last >= 0) check("R3", k - last, ((seen - 1) % 4 == 3) ? 5 : 4);
            last = k;
            seen++;
         end
         @(negedge clk);
      end
      pulses = seen;
   endtask

   initial begin : watchdog
      #(5.0 * 200000);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog act=0 exp=1");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      int pulses;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: outputs quiet while reset held
      check("R1", int'(ser_en), 0);
      check("R1", int'(ser_clk), 0);
      check("R1", int'(cpu_en), 0);
      rst = 1'b0;
      @(negedge clk);
      // R2: all outputs high in first running cycle
      check("R2", int'(ser_en & ser_clk & cpu_en), 1);
      run_seq(17 * 8, pulses);
      // R4: four pulses per 17 cycles over eight frames
      check("R4", pulses, 32);

      for (int p = 0; p < 17; p++) begin
         repeat (p) @(negedge clk);
         rst = 1'b1;
         @(negedge clk);
         check("R1", int'(ser_en | ser_clk | cpu_en), 0);
         rst = 1'b0;
         @(negedge clk);
         check("R2", int'(ser_en & ser_clk & cpu_en), 1);
         run_seq(40, pulses);
         // R8: restart yields 10 pulses in 40 cycles (0,4,8,12,17,21,25,29,34,38)
         check("R8", pulses, 10);
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule